// File: doc/BRIEF.md
# Address Resolution Request Sequencer

This block turns a 32-bit IP address from a client into the 48-bit MAC address behind it. Each lookup tries three sources in order: a single-entry cache held inside the block, then an external lookup store read over a request/done handshake, and finally a resolution request sent out to the network. The network path ends in one of three ways: a reply for the wanted address arrives, a timeout in the seconds range expires, or too many replies for other addresses arrive.

When gateway use is enabled, a target outside the local subnet is replaced by the gateway address before any lookup. The cache, the store read and the network request then all use the gateway address. The client sees a ready flag while the block is idle and gets exactly one result pulse per accepted request. The pulse carries a status code and, on success, the MAC. The whole block runs in one clock domain.

Top module: `addr_resolve_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. It drops on the clock edge after a request is accepted. A `req_valid_i` asserted while it is low is ignored: it causes no store read, no network request and no result.
- R2: When the cache holds the effective target, the result has status 0 (OK) and the cached MAC. `res_valid_o` rises on the first clock edge after the accepting edge, with no store read and no network request.
- R3: On a cache miss, `st_rd_valid_o` rises with the effective target on `st_rd_ip_o`. Both are held until `st_rd_done_i`. If `st_rd_hit_i` is high with done, the result is OK with `st_rd_mac_i`, and no network request is made.
- R4: When the store misses, `nwk_req_o` pulses for one cycle with the effective target on `nwk_req_ip_o`.
- R5: A reply (`nwk_rsp_valid_i`) whose IP equals the pending target ends the request with OK and the reply MAC. That pair, and any pair found in the store, is loaded into the cache, so the next lookup of it hits.
- R6: With gateway use enabled, if `(req_ip_i & netmask_i) != (our_ip_i & netmask_i)`, the effective target is `gateway_i`.
- R7: If no matching reply arrives, the result has status 1 (TIMEOUT) exactly T+1 cycles after the cycle in which `nwk_req_o` is high. T is `SIM_TICKS` when that is nonzero, else `CLK_HZ*TMO_SEC`.
- R8: The MAX_BAD-th non-matching reply during one pending request ends it with status 2 (ERROR). Earlier non-matching replies produce no result.
- R9: A one-cycle pulse on `cache_clr_i` invalidates the cache, so the next lookup of a previously cached address reads the store again.
- R10: `res_valid_o` is a one-cycle pulse issued once per accepted request. `res_mac_o` is zero when the status is not OK.
- R11: After reset, `req_ready_o` is high and `res_valid_o`, `st_rd_valid_o` and `nwk_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Client lookup request |
| req_ip_i | input | 32 | IP address to resolve |
| req_ready_o | output | 1 | Idle, request accepted |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_status_o | output | 2 | 0 OK, 1 TIMEOUT, 2 ERROR |
| res_mac_o | output | 48 | Resolved MAC, zero unless OK |
| st_rd_valid_o | output | 1 | Store read request, held until done |
| st_rd_ip_o | output | 32 | Address read from the store |
| st_rd_done_i | input | 1 | Store read complete |
| st_rd_hit_i | input | 1 | Store held the address |
| st_rd_mac_i | input | 48 | MAC from the store |
| nwk_req_o | output | 1 | One-cycle network resolution request |
| nwk_req_ip_o | output | 32 | Address to resolve on the network |
| nwk_rsp_valid_i | input | 1 | Network reply received |
| nwk_rsp_ip_i | input | 32 | IP in the reply |
| nwk_rsp_mac_i | input | 48 | MAC in the reply |
| our_ip_i | input | 32 | Local IP address |
| gateway_i | input | 32 | Gateway IP address |
| netmask_i | input | 32 | Subnet mask |
| cache_clr_i | input | 1 | Invalidate the cache entry |

## Verification
A stale or missing cache entry shows at the ports as a store read that should not happen, or one that is missing. This appears one cycle after acceptance, well before the result. A wrong gateway decision shows on `st_rd_ip_o` in that same cycle. An off-by-one in the timeout counter moves the TIMEOUT pulse by a cycle relative to `nwk_req_o`. A bad-reply counter that is not cleared, or that counts wrongly, ends a request one reply early or late.

// File: rtl/addr_resolve_pkg.sv
package addr_resolve_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_ERROR   = 2'd2
  } res_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_STORE, S_NREQ, S_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [31:0] ip;
    logic [47:0] mac;
  } addr_pair_t;
endpackage

// File: rtl/resolve_target.sv
module resolve_target #(
  parameter bit USE_GATEWAY = 1'b1,
  parameter int IP_W        = 32
) (
  input  logic [IP_W-1:0] ip_i,
  input  logic [IP_W-1:0] our_ip_i,
  input  logic [IP_W-1:0] gateway_i,
  input  logic [IP_W-1:0] netmask_i,
  output logic [IP_W-1:0] eff_ip_o
);
  generate
    if (USE_GATEWAY) begin : g_gw
      logic off_net;
      assign off_net  = (ip_i & netmask_i) != (our_ip_i & netmask_i);
      assign eff_ip_o = off_net ? gateway_i : ip_i;
    end else begin : g_direct
      logic [IP_W-1:0] unused_xor;
      assign unused_xor = our_ip_i ^ gateway_i ^ netmask_i;
      assign eff_ip_o   = ip_i;
    end
  endgenerate
endmodule

// File: rtl/resolve_cache.sv
module resolve_cache
  import addr_resolve_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        load_i,
  input  addr_pair_t  load_pair_i,
  input  logic [31:0] probe_ip_i,
  output logic        hit_o,
  output logic [47:0] mac_o
);
  logic       vld_q;
  addr_pair_t ent_q;

  // clear wins over a same-cycle load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      ent_q <= load_pair_i;
    end
  end

  assign hit_o = vld_q && (ent_q.ip == probe_ip_i);
  assign mac_o = ent_q.mac;
endmodule

// File: rtl/resolve_timer.sv
module resolve_timer #(
  parameter longint unsigned TMO_CYC = 64'd7500000000,
  parameter int              MAX_BAD = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic bad_i,
  output logic expired_o,
  output logic bad_limit_o
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam int BAD_W = $clog2(MAX_BAD + 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);
  localparam logic [BAD_W-1:0] BAD_LAST = BAD_W'(MAX_BAD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BAD_W-1:0] bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      bad_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (bad_i) bad_q <= bad_q + 1'b1;
    end
  end

  assign expired_o   = run_i && (cnt_q == TMO_LAST);
  assign bad_limit_o = run_i && bad_i && (bad_q == BAD_LAST);
endmodule

// File: rtl/addr_resolve_seq.sv
module addr_resolve_seq
  import addr_resolve_pkg::*;
#(
  parameter bit USE_GATEWAY = 1'b1,
  parameter int CLK_HZ      = 125000000,
  parameter int TMO_SEC     = 60,
  parameter int MAX_BAD     = 5,
  parameter int SIM_TICKS   = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_ip_i,
  output logic        req_ready_o,
  output logic        res_valid_o,
  output logic [1:0]  res_status_o,
  output logic [47:0] res_mac_o,
  output logic        st_rd_valid_o,
  output logic [31:0] st_rd_ip_o,
  input  logic        st_rd_done_i,
  input  logic        st_rd_hit_i,
  input  logic [47:0] st_rd_mac_i,
  output logic        nwk_req_o,
  output logic [31:0] nwk_req_ip_o,
  input  logic        nwk_rsp_valid_i,
  input  logic [31:0] nwk_rsp_ip_i,
  input  logic [47:0] nwk_rsp_mac_i,
  input  logic [31:0] our_ip_i,
  input  logic [31:0] gateway_i,
  input  logic [31:0] netmask_i,
  input  logic        cache_clr_i
);
  localparam longint unsigned TMO_CYC =
    (SIM_TICKS != 0) ? 64'(SIM_TICKS) : 64'(CLK_HZ) * 64'(TMO_SEC);

  seq_state_e  state_q, state_d;
  logic [31:0] tgt_q, eff_ip;
  logic        res_valid_q, res_valid_d;
  res_status_e res_status_q, res_status_d;
  logic [47:0] res_mac_q, res_mac_d;

  logic        c_hit, c_load;
  logic [47:0] c_mac;
  addr_pair_t  c_pair;
  logic        t_start, t_run, t_bad, t_expired, t_bad_limit;
  logic        rsp_match;

  resolve_target #(.USE_GATEWAY(USE_GATEWAY), .IP_W(32)) i_target (
    .ip_i      (req_ip_i),
    .our_ip_i  (our_ip_i),
    .gateway_i (gateway_i),
    .netmask_i (netmask_i),
    .eff_ip_o  (eff_ip)
  );

  resolve_cache i_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cache_clr_i),
    .load_i      (c_load),
    .load_pair_i (c_pair),
    .probe_ip_i  (tgt_q),
    .hit_o       (c_hit),
    .mac_o       (c_mac)
  );

  resolve_timer #(.TMO_CYC(TMO_CYC), .MAX_BAD(MAX_BAD)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (t_start),
    .run_i       (t_run),
    .bad_i       (t_bad),
    .expired_o   (t_expired),
    .bad_limit_o (t_bad_limit)
  );

  assign rsp_match = nwk_rsp_valid_i && (nwk_rsp_ip_i == tgt_q);
  assign t_start   = (state_q == S_NREQ);
  assign t_run     = (state_q == S_WAIT);
  assign t_bad     = nwk_rsp_valid_i && !rsp_match;

  always_comb begin
    state_d      = state_q;
    res_valid_d  = 1'b0;
    res_status_d = res_status_q;
    res_mac_d    = res_mac_q;
    c_load       = 1'b0;
    c_pair       = '{ip: tgt_q, mac: '0};
    unique case (state_q)
      S_IDLE: if (req_valid_i) state_d = S_LOOKUP;
      S_LOOKUP: begin
        if (c_hit) begin
          state_d      = S_IDLE;
          res_valid_d  = 1'b1;
          res_status_d = RES_OK;
          res_mac_d    = c_mac;
        end else begin
          state_d = S_STORE;
        end
      end
      S_STORE: begin
        if (st_rd_done_i) begin
          if (st_rd_hit_i) begin
            state_d      = S_IDLE;
            res_valid_d  = 1'b1;
            res_status_d = RES_OK;
            res_mac_d    = st_rd_mac_i;
            c_load       = 1'b1;
            c_pair.mac   = st_rd_mac_i;
          end else begin
            state_d = S_NREQ;
          end
        end
      end
      S_NREQ: state_d = S_WAIT;
      S_WAIT: begin
        // a matching reply wins over timeout in the same cycle
        if (rsp_match) begin
          state_d      = S_IDLE;
          res_valid_d  = 1'b1;
          res_status_d = RES_OK;
          res_mac_d    = nwk_rsp_mac_i;
          c_load       = 1'b1;
          c_pair.mac   = nwk_rsp_mac_i;
        end else if (t_bad_limit) begin
          state_d      = S_IDLE;
          res_valid_d  = 1'b1;
          res_status_d = RES_ERROR;
          res_mac_d    = '0;
        end else if (t_expired) begin
          state_d      = S_IDLE;
          res_valid_d  = 1'b1;
          res_status_d = RES_TIMEOUT;
          res_mac_d    = '0;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      tgt_q        <= '0;
      res_valid_q  <= 1'b0;
      res_status_q <= RES_OK;
      res_mac_q    <= '0;
    end else begin
      state_q      <= state_d;
      res_valid_q  <= res_valid_d;
      res_status_q <= res_status_d;
      res_mac_q    <= res_mac_d;
      if (state_q == S_IDLE && req_valid_i) tgt_q <= eff_ip;
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign res_valid_o   = res_valid_q;
  assign res_status_o  = res_status_q;
  assign res_mac_o     = res_mac_q;
  assign st_rd_valid_o = (state_q == S_STORE);
  assign st_rd_ip_o    = tgt_q;
  assign nwk_req_o     = (state_q == S_NREQ);
  assign nwk_req_ip_o  = tgt_q;
endmodule

// File: rtl/addr_resolve_seq_chk.sv
module addr_resolve_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        res_valid_o,
  input logic [1:0]  res_status_o,
  input logic [47:0] res_mac_o,
  input logic        st_rd_valid_o,
  input logic [31:0] st_rd_ip_o,
  input logic        st_rd_done_i,
  input logic        nwk_req_o
);
  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_rd_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd_valid_o && !st_rd_done_i |=> st_rd_valid_o && $stable(st_rd_ip_o));

  assert_nwk_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nwk_req_o |=> !nwk_req_o);

  assert_res_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_res_mac_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_status_o != 2'd0 |-> res_mac_o == 48'd0);

  assert_res_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_status_o != 2'd3);

  assert_phase_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_valid_o, st_rd_valid_o, nwk_req_o}));

  assert_res_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> req_ready_o);
endmodule

bind addr_resolve_seq addr_resolve_seq_chk i_chk (.*);

// File: tb/test_addr_resolve_seq.sv
module test_addr_resolve_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 20;
  localparam int NBAD       = 3;

  localparam logic [31:0] OUR_IP = 32'h0A00_0005;
  localparam logic [31:0] MASK   = 32'hFFFF_FF00;
  localparam logic [31:0] GW     = 32'h0A00_0001;
  localparam logic [31:0] IP_A   = 32'h0A00_0010;
  localparam logic [31:0] IP_B   = 32'h0A00_0020;
  localparam logic [31:0] IP_C   = 32'h0A00_0021;
  localparam logic [31:0] IP_D   = 32'h0A00_0030;
  localparam logic [31:0] IP_E   = 32'h0A00_0040;
  localparam logic [31:0] FAR_1  = 32'h0B00_0001;
  localparam logic [31:0] FAR_2  = 32'h0C00_0002;
  localparam logic [47:0] MAC_A  = 48'h0201_0203_0405;
  localparam logic [47:0] MAC_B  = 48'h0211_1213_1415;
  localparam logic [47:0] MAC_G  = 48'h0221_2223_2425;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ip = '0;
  logic        req_ready, res_valid, st_rd_valid, nwk_req;
  logic [1:0]  res_status;
  logic [47:0] res_mac;
  logic [31:0] st_rd_ip, nwk_req_ip;
  logic        st_done = 1'b0, st_hit;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_ip = '0;
  logic [47:0] rsp_mac = '0;
  logic        cache_clr = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int res_cnt = 0, rd_cnt = 0, nwk_cnt = 0, res_cyc = 0, nwk_cyc = 0, acc_cyc = 0;
  logic [1:0]  last_status = '0;
  logic [47:0] last_mac = '0;
  logic [31:0] last_rd_ip = '0, last_nwk_ip = '0;
  logic        rd_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_resolve_seq #(.USE_GATEWAY(1'b1), .MAX_BAD(NBAD), .SIM_TICKS(TICKS)) i_addr_resolve_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ip_i(req_ip), .req_ready_o(req_ready),
    .res_valid_o(res_valid), .res_status_o(res_status), .res_mac_o(res_mac),
    .st_rd_valid_o(st_rd_valid), .st_rd_ip_o(st_rd_ip),
    .st_rd_done_i(st_done), .st_rd_hit_i(st_hit), .st_rd_mac_i(MAC_A),
    .nwk_req_o(nwk_req), .nwk_req_ip_o(nwk_req_ip),
    .nwk_rsp_valid_i(rsp_valid), .nwk_rsp_ip_i(rsp_ip), .nwk_rsp_mac_i(rsp_mac),
    .our_ip_i(OUR_IP), .gateway_i(GW), .netmask_i(MASK), .cache_clr_i(cache_clr)
  );

  // store model: holds only IP_A, answers one cycle after a read appears
  assign st_hit = (st_rd_ip == IP_A);
  always @(posedge clk) st_done <= st_rd_valid && !st_done;

  // monitor, sampled shortly after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (res_valid) begin
      res_cnt++; last_status = res_status; last_mac = res_mac; res_cyc = cyc;
    end
    if (st_rd_valid && !rd_prev) begin
      rd_cnt++; last_rd_ip = st_rd_ip;
    end
    rd_prev = st_rd_valid;
    if (nwk_req) begin
      nwk_cnt++; last_nwk_ip = nwk_req_ip; nwk_cyc = cyc;
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ip);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ip = ip;
    @(posedge clk); #2; acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_res(input int old);
    for (int i = 0; i < 200 && res_cnt == old; i++) @(negedge clk);
  endtask

  task automatic wait_nwk(input int old);
    for (int i = 0; i < 200 && nwk_cnt == old; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reply(input logic [31:0] ip, input logic [47:0] mac);
    rsp_valid = 1'b1; rsp_ip = ip; rsp_mac = mac;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
    chk({res_valid, st_rd_valid, nwk_req} == 3'b000, "R11 outputs idle",
        64'({res_valid, st_rd_valid, nwk_req}), 64'd0);
  endtask

  task automatic t_store_hit;
    int r0 = res_cnt, d0 = rd_cnt, n0 = nwk_cnt;
    issue(IP_A);
    wait_res(r0);
    chk(rd_cnt == d0 + 1, "R3 store read made", 64'(rd_cnt - d0), 64'd1);
    chk(last_rd_ip == IP_A, "R3 store read ip", 64'(last_rd_ip), 64'(IP_A));
    chk(last_status == 2'd0 && last_mac == MAC_A, "R3 store hit result", 64'(last_mac), 64'(MAC_A));
    chk(nwk_cnt == n0, "R3 no network request", 64'(nwk_cnt - n0), 64'd0);
  endtask

  task automatic t_cache_hit;
    int r0 = res_cnt, d0 = rd_cnt, n0 = nwk_cnt;
    issue(IP_A);
    wait_res(r0);
    chk(last_status == 2'd0 && last_mac == MAC_A, "R2 cache hit result", 64'(last_mac), 64'(MAC_A));
    chk(res_cyc == acc_cyc + 1, "R2 cache hit latency", 64'(res_cyc - acc_cyc), 64'd1);
    chk(rd_cnt == d0 && nwk_cnt == n0, "R2 no store or network access",
        64'(rd_cnt - d0 + nwk_cnt - n0), 64'd0);
  endtask

  task automatic t_net_ok;
    int r0 = res_cnt, d0 = rd_cnt, n0 = nwk_cnt;
    issue(IP_B);
    // request while busy must be ignored (R1)
    req_valid = 1'b1; req_ip = IP_C;
    #1;
    chk(req_ready == 1'b0, "R1 busy not ready", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_nwk(n0);
    chk(nwk_cnt == n0 + 1, "R4 one network pulse", 64'(nwk_cnt - n0), 64'd1);
    chk(last_nwk_ip == IP_B, "R4 network target", 64'(last_nwk_ip), 64'(IP_B));
    reply(IP_C, MAC_G);
    reply(IP_B, MAC_B);
    wait_res(r0);
    chk(last_status == 2'd0 && last_mac == MAC_B, "R5 reply result", 64'(last_mac), 64'(MAC_B));
    repeat (5) @(negedge clk);
    chk(res_cnt == r0 + 1, "R1 R10 one result only", 64'(res_cnt - r0), 64'd1);
    chk(rd_cnt == d0 + 1, "R1 busy request made no read", 64'(rd_cnt - d0), 64'd1);
    d0 = rd_cnt; r0 = res_cnt;
    issue(IP_B);
    wait_res(r0);
    chk(rd_cnt == d0 && last_mac == MAC_B, "R5 reply pair cached", 64'(last_mac), 64'(MAC_B));
  endtask

  task automatic t_gateway;
    int r0 = res_cnt, d0 = rd_cnt, n0 = nwk_cnt;
    issue(FAR_1);
    wait_nwk(n0);
    chk(last_rd_ip == GW, "R6 store read uses gateway", 64'(last_rd_ip), 64'(GW));
    chk(last_nwk_ip == GW, "R6 network uses gateway", 64'(last_nwk_ip), 64'(GW));
    reply(GW, MAC_G);
    wait_res(r0);
    chk(last_status == 2'd0 && last_mac == MAC_G, "R6 gateway mac", 64'(last_mac), 64'(MAC_G));
    d0 = rd_cnt; r0 = res_cnt;
    issue(FAR_2);
    wait_res(r0);
    chk(rd_cnt == d0 && last_mac == MAC_G, "R6 other remote hits gateway entry",
        64'(rd_cnt - d0), 64'd0);
  endtask

  task automatic t_timeout;
    int r0 = res_cnt, n0 = nwk_cnt;
    issue(IP_D);
    wait_nwk(n0);
    wait_res(r0);
    chk(last_status == 2'd1, "R7 timeout status", 64'(last_status), 64'd1);
    chk(last_mac == 48'd0, "R10 mac zero on timeout", 64'(last_mac), 64'd0);
    chk(res_cyc - nwk_cyc == TICKS + 1, "R7 timeout cycles", 64'(res_cyc - nwk_cyc), 64'(TICKS + 1));
  endtask

  task automatic t_bad;
    int r0 = res_cnt, n0 = nwk_cnt;
    issue(IP_E);
    wait_nwk(n0);
    for (int i = 0; i < NBAD - 1; i++) reply(IP_C, MAC_B);
    repeat (2) @(negedge clk);
    chk(res_cnt == r0, "R8 no result before limit", 64'(res_cnt - r0), 64'd0);
    reply(IP_C, MAC_B);
    wait_res(r0);
    chk(last_status == 2'd2 && last_mac == 48'd0, "R8 error after limit", 64'(last_status), 64'd2);
  endtask

  task automatic t_clear;
    int r0 = res_cnt, d0 = rd_cnt, n0 = nwk_cnt;
    @(negedge clk);
    cache_clr = 1'b1;
    @(negedge clk);
    cache_clr = 1'b0;
    issue(FAR_2);
    wait_nwk(n0);
    chk(rd_cnt == d0 + 1, "R9 store read after clear", 64'(rd_cnt - d0), 64'd1);
    reply(GW, MAC_G);
    wait_res(r0);
    chk(last_status == 2'd0 && last_mac == MAC_G, "R9 refilled after clear", 64'(last_mac), 64'(MAC_G));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_hit();
    t_cache_hit();
    t_net_ok();
    t_gateway();
    t_timeout();
    t_bad();
    t_clear();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule